// File: doc/BRIEF.md
# 64-bit Rotate and Mask Unit

A purely combinational datapath block for a 64-bit integer pipeline. One shared rotator, built from three rank-of-4:1 multiplexer stages, turns a source word left by 0 to 63 places. Two mask generators then shape the rotated word. One generator keeps all bits at or below an upper bound. The other keeps all bits at or above a lower bound. Output logic merges the rotated word with the masks, a sign fill and an optional insert word. The same hardware covers rotate-then-mask, logical left and right shifts and arithmetic right shifts, on either full 64-bit operands or 32-bit word operands.

The caller supplies the operation class, the shift or rotate amount, the two mask bounds and a handful of mode flags. The result and the arithmetic-shift carries settle within the same cycle. There is no clock, no state and no flow control: the block sits inside an execute stage, and that stage owns all timing. The house stream convention therefore does not apply, and every pin is a plain level.

All bit positions below count from 0 at the least significant bit. The operation class is encoded as 0 = clear outside a band, 1 = clear above (keep low part), 2 = clear below (keep high part), 3 = shift left, 4 = shift right, and 5 to 7 are unused.

Top module: `rotmask_unit`

## Requirements
- R1: Class 0 with lo_i <= hi_i returns the source rotated left by amt_i[5:0], with bits lo_i..hi_i kept and all other bits zero (insert off).
- R2: Class 0 with lo_i > hi_i uses a wrapped band: bit i is kept when i >= lo_i or i <= hi_i.
- R3: Class 1 keeps rotated bits hi_i..0 and clears the rest; class 2 keeps rotated bits 63..lo_i and clears the rest.
- R4: When pick_i is 1 and the class is 1 or 2, sel_i picks the class instead: sel_i = 0 acts as class 1 and sel_i = 1 acts as class 2. pick_i has no effect on other classes.
- R5: With word_i = 1, rotate classes rotate a word formed by repeating src_i[31:0] in both halves, and bit 5 of hi_i and lo_i is ignored.
- R6: Class 3 shifts left by amt_i[6:0] (64-bit) or amt_i[5:0] (word mode, result zero-extended from bit 31). An amount of 64 or more (32 or more in word mode) gives zero. In word mode amt_i[6] is ignored.
- R7: Class 4 with signed_i = 0 is a logical right shift by the same amounts as R6, and fills with zeros. In word mode the upper half of the result is zero.
- R8: Class 4 with signed_i = 1 fills vacated bits with the operand sign (bit 63, or bit 31 in word mode). The word-mode result is sign-extended to 64 bits. An over-range amount gives all sign bits.
- R9: For class 4 with signed_i = 1, carry_o is 1 exactly when the operand is negative and at least one 1 bit is shifted out (every operand bit counts as shifted out on an over-range amount). carry32_o equals carry_o. Both are 0 for all other operations.
- R10: When ins_en_i is 1 in classes 0 to 2, bits outside the kept mask come from ins_i instead of zero. ins_en_i and ins_i have no effect on classes 3 and 4.
- R11: signed_i has no effect on classes 0 to 3.
- R12: Classes 5 to 7 give a zero result and zero carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source operand |
| amt_i | input | 7 | Rotate or shift amount; bit 6 flags an over-range 64-bit shift |
| op_i | input | 3 | Operation class (0 to 4 defined) |
| hi_i | input | 6 | Upper bound of the kept band |
| lo_i | input | 6 | Lower bound of the kept band |
| word_i | input | 1 | 32-bit operand mode |
| signed_i | input | 1 | Arithmetic right shift when class is 4 |
| pick_i | input | 1 | Let sel_i choose between classes 1 and 2 |
| sel_i | input | 1 | Instruction selector bit used when pick_i is 1 |
| ins_en_i | input | 1 | Merge rotated bits into ins_i |
| ins_i | input | 64 | Insert target word |
| res_o | output | 64 | Result |
| carry_o | output | 1 | Arithmetic shift carry |
| carry32_o | output | 1 | Arithmetic shift carry, word view |

## Verification
A fixed mixed-nibble pattern is rotated under ordinary bands, wrapped bands, degenerate single-bit bands and full bands. This separates a correct wrap decision from a plain AND of the two masks, and an off-by-one on either bound from an exact match. Shifts are tried at amounts 0, 1, the last legal amount and the first over-range amount, in both widths. Word mode is driven with a set bit 6 alone, which exposes a design that tests the wrong overflow bit. Arithmetic shifts use negative sources whose shifted-out bits are all zero, and then a single one, so the carry is shown to depend on the lost bits and not only on the sign. A pseudo-random sweep over every class and flag then compares each result bit against an independent bit-loop model.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
  // operation classes; the codes are part of the port contract
  typedef enum logic [2:0] {
    RC_BAND = 3'd0,
    RC_CLRH = 3'd1,
    RC_CLRL = 3'd2,
    RC_SHL  = 3'd3,
    RC_SHR  = 3'd4
  } rclass_t;
endpackage

// File: rtl/rlm_rotator.sv
module rlm_rotator #(
  parameter int DW = 64,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] amt,
  output logic [DW-1:0] dout
);
  localparam int NST = (SW + 1) / 2;
  localparam int AW  = 2 * NST;

  function automatic logic [DW-1:0] rotl(input logic [DW-1:0] x, input int k);
    logic [2*DW-1:0] d;
    d = {x, x} << (k % DW);
    return d[2*DW-1:DW];
  endfunction

  logic [AW-1:0] a_ext;
  logic [DW-1:0] stg [0:NST];

  assign a_ext  = AW'(amt);
  assign stg[0] = din;

  for (genvar s = 0; s < NST; s++) begin : g_stage
    logic [DW-1:0] so;
    always_comb begin
      case (a_ext[2*s +: 2])
        2'd0:    so = stg[s];
        2'd1:    so = rotl(stg[s], (4 ** s));
        2'd2:    so = rotl(stg[s], 2 * (4 ** s));
        default: so = rotl(stg[s], 3 * (4 ** s));
      endcase
    end
    assign stg[s+1] = so;
  end

  assign dout = stg[NST];

  always_comb begin
    // R1
    ones_kept_chk: assert ($countones(dout) == $countones(din));
  end
endmodule

// File: rtl/rlm_mask_gen.sv
module rlm_mask_gen #(
  parameter int DW = 64,
  parameter bit KEEP_BELOW = 1'b1,
  localparam int SW = $clog2(DW)
) (
  input  logic [SW-1:0] bound,
  output logic [DW-1:0] mask
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (KEEP_BELOW) begin : g_below
      assign mask[i] = (SW'(i) <= bound);
    end else begin : g_above
      assign mask[i] = (SW'(i) >= bound);
    end
  end

  always_comb begin
    // R3
    band_width_chk: assert ($countones(mask) ==
      (KEEP_BELOW ? int'(bound) + 1 : DW - int'(bound)));
  end
endmodule

// File: rtl/rlm_ctrl.sv
module rlm_ctrl
  import rlm_pkg::*;
#(
  parameter int DW = 64,
  localparam int SW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input  logic [2:0]    op_i,
  input  logic          pick_i,
  input  logic          sel_i,
  input  logic          word_i,
  input  logic          signed_i,
  input  logic          ins_en_i,
  input  logic [SW:0]   amt_i,
  input  logic [SW-1:0] hi_i,
  input  logic [SW-1:0] lo_i,
  output logic [SW-1:0] rot_o,
  output logic [SW-1:0] mhi_o,
  output logic [SW-1:0] mlo_o,
  output logic          wrap_o,
  output logic          kill_o,
  output logic          arith_o,
  output logic          ins_o,
  output logic          shift_o
);
  logic [2:0]    cls;
  logic [SW-1:0] top_idx, n, hb, lb;
  logic          over;

  always_comb begin
    cls = op_i;
    if (pick_i && (op_i == RC_CLRH || op_i == RC_CLRL))
      cls = sel_i ? RC_CLRL : RC_CLRH;
    top_idx = word_i ? SW'(HW - 1) : SW'(DW - 1);
    n       = word_i ? {1'b0, amt_i[SW-2:0]} : amt_i[SW-1:0];
    over    = word_i ? amt_i[SW-1] : amt_i[SW];
    hb      = word_i ? {1'b0, hi_i[SW-2:0]} : hi_i;
    lb      = word_i ? {1'b0, lo_i[SW-2:0]} : lo_i;

    rot_o   = amt_i[SW-1:0];
    mhi_o   = hb;
    mlo_o   = lb;
    wrap_o  = 1'b0;
    kill_o  = 1'b0;
    arith_o = 1'b0;
    ins_o   = 1'b0;
    shift_o = 1'b0;
    case (cls)
      RC_BAND: begin
        wrap_o = (lb > hb);
        ins_o  = ins_en_i;
      end
      RC_CLRH: begin
        mlo_o = '0;
        ins_o = ins_en_i;
      end
      RC_CLRL: begin
        mhi_o = SW'(DW - 1);
        ins_o = ins_en_i;
      end
      RC_SHL: begin
        rot_o   = n;
        mhi_o   = top_idx;
        mlo_o   = n;
        kill_o  = over;
        shift_o = 1'b1;
      end
      RC_SHR: begin
        rot_o   = SW'(0) - n;
        mhi_o   = top_idx - n;
        mlo_o   = '0;
        kill_o  = over;
        arith_o = signed_i;
        shift_o = 1'b1;
      end
      default: kill_o = 1'b1;
    endcase
  end

  always_comb begin
    // R4
    pick_class_chk: assert (!(pick_i && op_i == RC_CLRL && !sel_i) || mlo_o == '0);
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int DW = 64,
  localparam int SW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input  logic [DW-1:0] src_i,
  input  logic [SW:0]   amt_i,
  input  logic [2:0]    op_i,
  input  logic [SW-1:0] hi_i,
  input  logic [SW-1:0] lo_i,
  input  logic          word_i,
  input  logic          signed_i,
  input  logic          pick_i,
  input  logic          sel_i,
  input  logic          ins_en_i,
  input  logic [DW-1:0] ins_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o,
  output logic          carry32_o
);
  logic [SW-1:0] rot, mhi, mlo;
  logic          wrap, kill, arith, use_ins, shift;
  logic [DW-1:0] opnd, rv, up, lw, m, fill, lost, spill;
  logic          sgn;

  rlm_ctrl #(.DW(DW)) u_ctrl (
    .op_i(op_i), .pick_i(pick_i), .sel_i(sel_i), .word_i(word_i),
    .signed_i(signed_i), .ins_en_i(ins_en_i), .amt_i(amt_i),
    .hi_i(hi_i), .lo_i(lo_i), .rot_o(rot), .mhi_o(mhi), .mlo_o(mlo),
    .wrap_o(wrap), .kill_o(kill), .arith_o(arith), .ins_o(use_ins),
    .shift_o(shift)
  );

  // word mode repeats the low half so both halves rotate consistently
  assign opnd = word_i ? {src_i[HW-1:0], src_i[HW-1:0]} : src_i;

  rlm_rotator #(.DW(DW)) u_rot (.din(opnd), .amt(rot), .dout(rv));

  rlm_mask_gen #(.DW(DW), .KEEP_BELOW(1'b1)) u_mask_up (.bound(mhi), .mask(up));
  rlm_mask_gen #(.DW(DW), .KEEP_BELOW(1'b0)) u_mask_lw (.bound(mlo), .mask(lw));

  always_comb begin
    m     = kill ? '0 : (wrap ? (up | lw) : (up & lw));
    sgn   = word_i ? src_i[HW-1] : src_i[DW-1];
    fill  = kill ? '1 : ~up;
    spill = rv & ~up;
    if (kill)
      lost = word_i ? {{HW{1'b0}}, src_i[HW-1:0]} : src_i;
    else
      lost = word_i ? {{HW{1'b0}}, spill[HW-1:0]} : spill;
    res_o     = (rv & m) | ({DW{arith & sgn}} & fill) | ({DW{use_ins}} & ins_i & ~m);
    carry_o   = arith & sgn & (|lost);
    carry32_o = carry_o;
  end

  always_comb begin
    // R6
    ovr_zero_chk: assert (!(kill && !arith) || res_o == '0);
    // R9
    carry_gate_chk: assert (arith || (!carry_o && !carry32_o));
    // R10
    ins_keep_chk: assert (!use_ins || ((res_o ^ ins_i) & ~m) == '0);
    // R7
    word_upper_chk: assert (!(word_i && shift && !arith) || res_o[DW-1:HW] == '0);
  end
endmodule

// File: tb/sim_rotmask_unit.sv
module sim_rotmask_unit;
  localparam int DW = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] src, ins;
  logic [6:0]  amt;
  logic [2:0]  op;
  logic [5:0]  hi, lo;
  logic        word, sg, pick, sel, insen;
  logic [63:0] res;
  logic        ca, ca32;

  int total = 0;
  int bad   = 0;
  logic [63:0] lfsr = 64'h9E3779B97F4A7C15;

  rotmask_unit #(.DW(DW)) u0 (
    .src_i(src), .amt_i(amt), .op_i(op), .hi_i(hi), .lo_i(lo),
    .word_i(word), .signed_i(sg), .pick_i(pick), .sel_i(sel),
    .ins_en_i(insen), .ins_i(ins), .res_o(res), .carry_o(ca),
    .carry32_o(ca32)
  );

  // bit-loop reference built from the requirements
  function automatic logic [65:0] model(
    input logic [63:0] s, input logic [6:0] a, input logic [2:0] opc,
    input logic [5:0] h, input logic [5:0] l, input logic w, input logic sgi,
    input logic pk, input logic sl, input logic ie, input logic [63:0] iv);
    logic [63:0] x, d, r, y;
    logic        sign, c, keep;
    int          n, ow, hh, ll, k;
    y = '0; c = 1'b0; r = '0; sign = 1'b0;
    if (pk && (opc == 3'd1 || opc == 3'd2)) opc = sl ? 3'd2 : 3'd1;
    ow = w ? 32 : 64;
    x  = w ? {32'h0, s[31:0]} : s;
    if (opc <= 3'd2) begin
      d  = w ? {s[31:0], s[31:0]} : s;
      k  = int'(a[5:0]);
      for (int i = 0; i < 64; i++) r[(i + k) % 64] = d[i];
      hh = w ? int'(h) % 32 : int'(h);
      ll = w ? int'(l) % 32 : int'(l);
      for (int i = 0; i < 64; i++) begin
        if (opc == 3'd0)
          keep = (ll <= hh) ? (i >= ll && i <= hh) : (i >= ll || i <= hh);
        else if (opc == 3'd1)
          keep = (i <= hh);
        else
          keep = (i >= ll);
        y[i] = keep ? r[i] : (ie & iv[i]);
      end
    end else if (opc == 3'd3) begin
      n = w ? int'(a[5:0]) : int'(a);
      for (int i = 0; i < ow; i++) if (i >= n) y[i] = x[i - n];
    end else if (opc == 3'd4) begin
      n = w ? int'(a[5:0]) : int'(a);
      sign = sgi & x[ow - 1];
      for (int i = 0; i < ow; i++) y[i] = (i + n < ow) ? x[i + n] : sign;
      for (int i = 0; i < ow; i++) if (i < n) c = c | x[i];
      c = c & sign;
      if (w) y[63:32] = {32{sign}};
    end
    return {c, c, y};
  endfunction

  task automatic run(input string req, input logic [63:0] s, input logic [6:0] a,
                     input logic [2:0] opc, input logic [5:0] h, input logic [5:0] l,
                     input logic w, input logic sgi, input logic pk, input logic sl,
                     input logic ie, input logic [63:0] iv);
    logic [65:0] exp;
    @(negedge clk);
    src = s; amt = a; op = opc; hi = h; lo = l; word = w; sg = sgi;
    pick = pk; sel = sl; insen = ie; ins = iv;
    #1;
    exp = model(s, a, opc, h, l, w, sgi, pk, sl, ie, iv);
    total++;
    if ({ca32, ca, res} !== exp) begin
      bad++;
      $display("FAIL %s: got res=%h ca=%b ca32=%b expected res=%h ca=%b ca32=%b",
               req, res, ca, ca32, exp[63:0], exp[64], exp[65]);
    end
  endtask

  function automatic logic [63:0] nxt(input logic [63:0] v);
    logic [63:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 7);
    return t ^ (t << 17);
  endfunction

  localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] NEG = 64'hF000_0000_0000_0F00;
  localparam logic [63:0] IV  = 64'hA5A5_5A5A_C3C3_3C3C;

  task automatic t_idle;
    run("R1 idle", 64'h0, 7'd0, 3'd0, 6'd0, 6'd0, 0, 0, 0, 0, 0, 64'h0);
  endtask

  task automatic t_band;   // R1
    run("R1 band", PAT, 7'd8, 3'd0, 6'd47, 6'd16, 0, 0, 0, 0, 0, 64'h0);
    run("R1 full", PAT, 7'd63, 3'd0, 6'd63, 6'd0, 0, 0, 0, 0, 0, 64'h0);
    run("R1 single", PAT, 7'd5, 3'd0, 6'd9, 6'd9, 0, 0, 0, 0, 0, 64'h0);
  endtask

  task automatic t_wrap;   // R2
    run("R2 wrap", PAT, 7'd20, 3'd0, 6'd10, 6'd50, 0, 0, 0, 0, 0, 64'h0);
    run("R2 wrap adj", PAT, 7'd1, 3'd0, 6'd30, 6'd31, 0, 0, 0, 0, 0, 64'h0);
  endtask

  task automatic t_single; // R3
    run("R3 clear high", PAT, 7'd12, 3'd1, 6'd31, 6'd40, 0, 0, 0, 0, 0, 64'h0);
    run("R3 clear low", PAT, 7'd12, 3'd2, 6'd5, 6'd40, 0, 0, 0, 0, 0, 64'h0);
  endtask

  task automatic t_pick;   // R4
    run("R4 pick to clear low", PAT, 7'd3, 3'd1, 6'd20, 6'd44, 0, 0, 1, 1, 0, 64'h0);
    run("R4 pick to clear high", PAT, 7'd3, 3'd2, 6'd20, 6'd44, 0, 0, 1, 0, 0, 64'h0);
    run("R4 pick ignored band", PAT, 7'd3, 3'd0, 6'd20, 6'd4, 0, 0, 1, 1, 0, 64'h0);
  endtask

  task automatic t_word;   // R5
    run("R5 word rot", PAT, 7'd7, 3'd0, 6'd60, 6'd35, 1, 0, 0, 0, 0, 64'h0);
    run("R5 word wrap", PAT, 7'd29, 3'd0, 6'd3, 6'd27, 1, 0, 0, 0, 0, 64'h0);
  endtask

  task automatic t_shl;    // R6
    run("R6 shl 0", PAT, 7'd0, 3'd3, 6'd0, 6'd0, 0, 0, 0, 0, 0, 64'h0);
    run("R6 shl 63", PAT, 7'd63, 3'd3, 6'd0, 6'd0, 0, 0, 0, 0, 0, 64'h0);
    run("R6 shl 64", PAT, 7'd64, 3'd3, 6'd0, 6'd0, 0, 0, 0, 0, 0, 64'h0);
    run("R6 word shl 31", PAT, 7'd31, 3'd3, 6'd0, 6'd0, 1, 0, 0, 0, 0, 64'h0);
    run("R6 word shl 32", PAT, 7'd32, 3'd3, 6'd0, 6'd0, 1, 0, 0, 0, 0, 64'h0);
    run("R6 word bit6 ignored", PAT, 7'd67, 3'd3, 6'd0, 6'd0, 1, 0, 0, 0, 0, 64'h0);
  endtask

  task automatic t_shr;    // R7
    run("R7 shr 1", NEG, 7'd1, 3'd4, 6'd0, 6'd0, 0, 0, 0, 0, 0, 64'h0);
    run("R7 shr 100", NEG, 7'd100, 3'd4, 6'd0, 6'd0, 0, 0, 0, 0, 0, 64'h0);
    run("R7 word shr", 64'hFFFF_FFFF_8765_4321, 7'd4, 3'd4, 6'd0, 6'd0, 1, 0, 0, 0, 0, 64'h0);
  endtask

  task automatic t_sra;    // R8
    run("R8 sra 8", NEG, 7'd8, 3'd4, 6'd0, 6'd0, 0, 1, 0, 0, 0, 64'h0);
    run("R8 sra over", NEG, 7'd64, 3'd4, 6'd0, 6'd0, 0, 1, 0, 0, 0, 64'h0);
    run("R8 word sra", 64'h0000_0000_8000_0010, 7'd4, 3'd4, 6'd0, 6'd0, 1, 1, 0, 0, 0, 64'h0);
    run("R8 word sra over", 64'h0000_0000_8000_0000, 7'd33, 3'd4, 6'd0, 6'd0, 1, 1, 0, 0, 0, 64'h0);
  endtask

  task automatic t_carry;  // R9
    run("R9 no ones lost", NEG, 7'd8, 3'd4, 6'd0, 6'd0, 0, 1, 0, 0, 0, 64'h0);
    run("R9 one lost", NEG, 7'd9, 3'd4, 6'd0, 6'd0, 0, 1, 0, 0, 0, 64'h0);
    run("R9 positive", 64'h0FFF_FFFF_FFFF_FFFF, 7'd9, 3'd4, 6'd0, 6'd0, 0, 1, 0, 0, 0, 64'h0);
    run("R9 word lost", 64'h0000_0000_8000_0001, 7'd1, 3'd4, 6'd0, 6'd0, 1, 1, 0, 0, 0, 64'h0);
  endtask

  task automatic t_insert; // R10
    run("R10 insert band", PAT, 7'd16, 3'd0, 6'd39, 6'd24, 0, 0, 0, 0, 1, IV);
    run("R10 insert wrap", PAT, 7'd4, 3'd0, 6'd2, 6'd60, 0, 0, 0, 0, 1, IV);
    run("R10 insert ignored shl", PAT, 7'd4, 3'd3, 6'd0, 6'd0, 0, 0, 0, 0, 1, IV);
    run("R10 insert ignored shr", NEG, 7'd4, 3'd4, 6'd0, 6'd0, 0, 1, 0, 0, 1, IV);
  endtask

  task automatic t_signed; // R11
    run("R11 signed rot", NEG, 7'd9, 3'd0, 6'd50, 6'd3, 0, 1, 0, 0, 0, 64'h0);
    run("R11 signed shl", NEG, 7'd9, 3'd3, 6'd0, 6'd0, 0, 1, 0, 0, 0, 64'h0);
  endtask

  task automatic t_badcls; // R12
    for (int c = 5; c < 8; c++)
      run("R12 unused class", NEG, 7'd70, 3'(c), 6'd50, 6'd3, 0, 1, 0, 0, 1, IV);
  endtask

  task automatic t_sweep;
    for (int j = 0; j < 300; j++) begin
      logic [63:0] a1, a2;
      lfsr = nxt(lfsr); a1 = lfsr;
      lfsr = nxt(lfsr); a2 = lfsr;
      run("R1 R2 R3 R5 R6 R7 R8 R9 R10 sweep", a1, a2[6:0], 3'(j % 5),
          a2[12:7], a2[18:13], a2[19], a2[20], a2[21], a2[22], a2[23], a2 ^ a1);
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog (all requirements): got hung run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    src = '0; ins = '0; amt = '0; op = '0; hi = '0; lo = '0;
    word = 0; sg = 0; pick = 0; sel = 0; insen = 0;
    repeat (3) @(posedge clk);
    t_idle();
    t_band();
    t_wrap();
    t_single();
    t_pick();
    t_word();
    t_shl();
    t_shr();
    t_sra();
    t_carry();
    t_insert();
    t_signed();
    t_badcls();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule